// File: doc/BRIEF.md
# Shared System Time Clock Unit

This block holds the 27 MHz system time clock (STC) for one channel of a multi-channel video encoder or decoder. The count has two parts. A 9-bit extension steps from 0 to 299 on each time-base tick. A 33-bit base steps at the resulting 90 kHz rate whenever the extension wraps back to 0. The 27 MHz rate reaches the block as a clock-enable tick, taken either from a local time base or from a distributed one. A channel runs as a master or as a slave. A master counts and drives its count onto a shared STC output. A slave ignores its own counter and follows the shared STC input, so that several channels show their sub-images on a single time base.

In decoder mode, a master builds its STC from received program clock reference (PCR) values. It loads the first PCR after reset directly. For each later PCR it compares the PCR with the count and reloads only when the signed gap exceeds a programmable threshold. In encoder mode, each channel stamps outgoing PCR words and presentation/decoding timestamps (PTS/DTS) from the STC it is using. The timestamps are placed a configurable margin ahead of the STC, which keeps the far-end buffer from draining or overflowing.

Top module: `stc_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the count and all registered outputs clear: stc_base = 0, stc_ext = 0, disc_flag = 0, lost_sync = 0, pcr_out_valid = 0, ts_valid = 0. A master decoder that has not loaded a PCR shows shr_stc_out_valid = 0.
- R2: In master mode (is_master = 1), each selected tick moves stc_ext up by one. When stc_ext is 299, a tick sets it to 0 and adds one to stc_base. stc_base wraps from 2^33-1 to 0. Each step is visible the cycle after the tick.
- R3: tick_sel = 0 counts tick_local and tick_sel = 1 counts tick_dist. The tick that is not selected has no effect on the count.
- R4: A master drives its count on shr_stc_out_base/ext. shr_stc_out_valid is 1 for a master encoder (is_encoder = 1) and for a master decoder that has loaded a PCR. A slave (is_master = 0) drives shr_stc_out_valid = 0.
- R5: A slave presents shr_stc_in on stc_base/ext one cycle after a cycle with shr_stc_in_valid = 1. Its own counter neither counts nor loads while it is a slave, so the count is unchanged when the channel returns to master mode.
- R6: A slave that sees shr_stc_in_valid = 0 holds its last STC and shows lost_sync = 1 on the next cycle. lost_sync returns to 0 the cycle after a valid input or after a return to master mode.
- R7: In master decoder mode, the first pcr_valid after reset loads pcr_base/pcr_ext into the count, visible the next cycle, without raising disc_flag.
- R8: Each later PCR in master decoder mode takes d = pcr_base - stc_base modulo 2^33, read as two's complement. If |d| > disc_thresh, the count reloads from the PCR and disc_flag pulses high for one cycle. If |d| <= disc_thresh, the PCR is ignored and counting goes on.
- R9: A PCR load in a cycle that also carries a selected tick takes priority, and that tick is dropped.
- R10: pcr_valid has no effect in encoder mode or in slave mode.
- R11: In encoder mode, pcr_req places the STC in use during the request cycle on pcr_out_base/ext, with pcr_out_valid high for one cycle on the next cycle.
- R12: In encoder mode, ts_req produces, on the next cycle, dts = stc_base + margin and pts = stc_base + margin + reorder (both modulo 2^33), with ts_valid high for one cycle. ts_req has no effect in decoder mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | 1 = master, 0 = slave |
| is_encoder | input | 1 | 1 = encoder mode, 0 = decoder mode |
| tick_sel | input | 1 | 0 = local tick, 1 = distributed tick |
| tick_local | input | 1 | Local 27 MHz time-base enable |
| tick_dist | input | 1 | Distributed 27 MHz time-base enable |
| pcr_valid | input | 1 | Received PCR strobe |
| pcr_base | input | 33 | Received PCR base |
| pcr_ext | input | 9 | Received PCR extension |
| disc_thresh | input | 33 | Largest gap accepted without reload, in base units |
| shr_stc_in_valid | input | 1 | Shared STC input valid |
| shr_stc_in_base | input | 33 | Shared STC input base |
| shr_stc_in_ext | input | 9 | Shared STC input extension |
| pcr_req | input | 1 | Request an outgoing PCR stamp |
| ts_req | input | 1 | Request a PTS/DTS pair |
| margin | input | 33 | Timestamp margin ahead of STC |
| reorder | input | 33 | Extra PTS delay over DTS |
| shr_stc_out_valid | output | 1 | Shared STC output valid |
| shr_stc_out_base | output | 33 | Shared STC output base |
| shr_stc_out_ext | output | 9 | Shared STC output extension |
| stc_base | output | 33 | STC in use, base |
| stc_ext | output | 9 | STC in use, extension |
| disc_flag | output | 1 | One-cycle discontinuity pulse |
| lost_sync | output | 1 | Slave lacks a valid shared STC |
| pcr_out_valid | output | 1 | Outgoing PCR stamp valid |
| pcr_out_base | output | 33 | Outgoing PCR base |
| pcr_out_ext | output | 9 | Outgoing PCR extension |
| ts_valid | output | 1 | Timestamp pair valid |
| pts | output | 33 | Presentation timestamp |
| dts | output | 33 | Decoding timestamp |

## Verification
A received PCR and a selected time-base tick can arrive in the same cycle, and the outcome then depends on whether the PCR loads the count. The bench forces this overlap twice. In the first case a first-after-reset PCR arrives together with a local tick, and the count must equal the PCR exactly, with no extra step. In the second case an in-threshold PCR arrives together with a distributed tick, and the count must advance by exactly one tick as if the PCR had not come. The two stamping requests are also raised together, and both results must come from the same STC.

// File: rtl/stc_pkg.sv
// Shared constants for the system time clock unit.
// Assumes a 33-bit 90 kHz base and a 0..299 extension at 27 MHz.
package stc_pkg;
    localparam int BASE_W  = 33;
    localparam int EXT_W   = 9;
    localparam int EXT_MOD = 300;
endpackage

// File: rtl/stc_counter.sv
// Base/extension time counter with a direct-load path.
// Assumes load and tick are one-cycle qualified strobes; load wins.
module stc_counter #(
    parameter int BASE_W  = stc_pkg::BASE_W,
    parameter int EXT_W   = stc_pkg::EXT_W,
    parameter int EXT_MOD = stc_pkg::EXT_MOD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              load,
    input  logic [BASE_W-1:0] ld_base,
    input  logic [EXT_W-1:0]  ld_ext,
    output logic [BASE_W-1:0] base,
    output logic [EXT_W-1:0]  ext
);
    localparam logic [EXT_W-1:0] EXT_LAST = EXT_W'(EXT_MOD - 1);

    // Advance, reload or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            ext  <= '0;
        end else if (load) begin
            base <= ld_base;
            ext  <= ld_ext;
        end else if (run && tick) begin
            if (ext == EXT_LAST) begin
                ext  <= '0;
                base <= base + BASE_W'(1);
            end else begin
                ext <= ext + EXT_W'(1);
            end
        end
    end
endmodule

// File: rtl/stc_pcr_track.sv
// Decides when a received PCR reloads the count in master decoder mode.
// Assumes the gap fits a signed BASE_W value (modulo 2^BASE_W).
module stc_pcr_track #(
    parameter int BASE_W = stc_pkg::BASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pcr_valid,
    input  logic [BASE_W-1:0] pcr_base,
    input  logic [BASE_W-1:0] cur_base,
    input  logic [BASE_W-1:0] thresh,
    output logic              load,
    output logic              loaded,
    output logic              disc
);
    logic [BASE_W-1:0] gap;
    logic [BASE_W-1:0] mag;
    logic              over;

    // Signed gap magnitude and threshold compare.
    always_comb begin
        gap  = pcr_base - cur_base;
        mag  = gap[BASE_W-1] ? (~gap + BASE_W'(1)) : gap;
        over = mag > thresh;
        load = enable && pcr_valid && (!loaded || over);
    end

    // Track first load and pulse on discontinuity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded <= 1'b0;
            disc   <= 1'b0;
        end else begin
            loaded <= loaded || (enable && pcr_valid);
            disc   <= enable && pcr_valid && loaded && over;
        end
    end
endmodule

// File: rtl/stc_stamp.sv
// Encoder-side stamping of outgoing PCR words and PTS/DTS pairs.
// Assumes stc inputs are the time base in use this cycle.
module stc_stamp #(
    parameter int BASE_W = stc_pkg::BASE_W,
    parameter int EXT_W  = stc_pkg::EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pcr_req,
    input  logic              ts_req,
    input  logic [BASE_W-1:0] cur_base,
    input  logic [EXT_W-1:0]  cur_ext,
    input  logic [BASE_W-1:0] margin,
    input  logic [BASE_W-1:0] reorder,
    output logic              pcr_out_valid,
    output logic [BASE_W-1:0] pcr_out_base,
    output logic [EXT_W-1:0]  pcr_out_ext,
    output logic              ts_valid,
    output logic [BASE_W-1:0] pts,
    output logic [BASE_W-1:0] dts
);
    logic [BASE_W-1:0] dts_n;

    // Next timestamp values, modulo 2^BASE_W.
    always_comb dts_n = cur_base + margin;

    // Capture stamps on request and pulse their valids.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcr_out_valid <= 1'b0;
            pcr_out_base  <= '0;
            pcr_out_ext   <= '0;
            ts_valid      <= 1'b0;
            pts           <= '0;
            dts           <= '0;
        end else begin
            pcr_out_valid <= enable && pcr_req;
            ts_valid      <= enable && ts_req;
            if (enable && pcr_req) begin
                pcr_out_base <= cur_base;
                pcr_out_ext  <= cur_ext;
            end
            if (enable && ts_req) begin
                dts <= dts_n;
                pts <= dts_n + reorder;
            end
        end
    end
endmodule

// File: rtl/stc_unit.sv
// Per-channel STC unit: master counter or slave follower, PCR tracking
// in decoder mode and stamping in encoder mode.
// Assumes ticks are one-cycle enables at the 27 MHz rate.
module stc_unit #(
    parameter int BASE_W  = stc_pkg::BASE_W,
    parameter int EXT_W   = stc_pkg::EXT_W,
    parameter int EXT_MOD = stc_pkg::EXT_MOD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              is_encoder,
    input  logic              tick_sel,
    input  logic              tick_local,
    input  logic              tick_dist,
    input  logic              pcr_valid,
    input  logic [BASE_W-1:0] pcr_base,
    input  logic [EXT_W-1:0]  pcr_ext,
    input  logic [BASE_W-1:0] disc_thresh,
    input  logic              shr_stc_in_valid,
    input  logic [BASE_W-1:0] shr_stc_in_base,
    input  logic [EXT_W-1:0]  shr_stc_in_ext,
    input  logic              pcr_req,
    input  logic              ts_req,
    input  logic [BASE_W-1:0] margin,
    input  logic [BASE_W-1:0] reorder,
    output logic              shr_stc_out_valid,
    output logic [BASE_W-1:0] shr_stc_out_base,
    output logic [EXT_W-1:0]  shr_stc_out_ext,
    output logic [BASE_W-1:0] stc_base,
    output logic [EXT_W-1:0]  stc_ext,
    output logic              disc_flag,
    output logic              lost_sync,
    output logic              pcr_out_valid,
    output logic [BASE_W-1:0] pcr_out_base,
    output logic [EXT_W-1:0]  pcr_out_ext,
    output logic              ts_valid,
    output logic [BASE_W-1:0] pts,
    output logic [BASE_W-1:0] dts
);
    logic              tick_pick;
    logic              ld;
    logic              pcr_loaded;
    logic [BASE_W-1:0] cnt_base;
    logic [EXT_W-1:0]  cnt_ext;
    logic [BASE_W-1:0] slv_base;
    logic [EXT_W-1:0]  slv_ext;

    // Choose the time-base tick.
    always_comb tick_pick = tick_sel ? tick_dist : tick_local;

    stc_pcr_track #(.BASE_W(BASE_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (is_master && !is_encoder),
        .pcr_valid(pcr_valid),
        .pcr_base (pcr_base),
        .cur_base (cnt_base),
        .thresh   (disc_thresh),
        .load     (ld),
        .loaded   (pcr_loaded),
        .disc     (disc_flag)
    );

    stc_counter #(.BASE_W(BASE_W), .EXT_W(EXT_W), .EXT_MOD(EXT_MOD)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (is_master),
        .tick   (tick_pick),
        .load   (ld),
        .ld_base(pcr_base),
        .ld_ext (pcr_ext),
        .base   (cnt_base),
        .ext    (cnt_ext)
    );

    // Slave follower: capture the shared STC or hold and flag loss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slv_base  <= '0;
            slv_ext   <= '0;
            lost_sync <= 1'b0;
        end else if (!is_master) begin
            if (shr_stc_in_valid) begin
                slv_base <= shr_stc_in_base;
                slv_ext  <= shr_stc_in_ext;
            end
            lost_sync <= !shr_stc_in_valid;
        end else begin
            lost_sync <= 1'b0;
        end
    end

    // Time base in use and shared output.
    always_comb begin
        stc_base          = is_master ? cnt_base : slv_base;
        stc_ext           = is_master ? cnt_ext  : slv_ext;
        shr_stc_out_base  = is_master ? cnt_base : '0;
        shr_stc_out_ext   = is_master ? cnt_ext  : '0;
        shr_stc_out_valid = is_master && (is_encoder || pcr_loaded);
    end

    stc_stamp #(.BASE_W(BASE_W), .EXT_W(EXT_W)) u_stamp (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (is_encoder),
        .pcr_req      (pcr_req),
        .ts_req       (ts_req),
        .cur_base     (stc_base),
        .cur_ext      (stc_ext),
        .margin       (margin),
        .reorder      (reorder),
        .pcr_out_valid(pcr_out_valid),
        .pcr_out_base (pcr_out_base),
        .pcr_out_ext  (pcr_out_ext),
        .ts_valid     (ts_valid),
        .pts          (pts),
        .dts          (dts)
    );
endmodule

// File: rtl/stc_unit_chk.sv
// Property checker for stc_unit, attached with bind.
// Assumes the internal count, load and follower names of stc_unit.
module stc_unit_chk #(
    parameter int BASE_W  = stc_pkg::BASE_W,
    parameter int EXT_W   = stc_pkg::EXT_W,
    parameter int EXT_MOD = stc_pkg::EXT_MOD
) (
    input logic              clk,
    input logic              rst_n,
    input logic              is_master,
    input logic              is_encoder,
    input logic              tick_sel,
    input logic              tick_local,
    input logic              tick_dist,
    input logic              ld,
    input logic [BASE_W-1:0] cnt_base,
    input logic [EXT_W-1:0]  cnt_ext,
    input logic [BASE_W-1:0] pcr_base,
    input logic              disc_flag,
    input logic              lost_sync,
    input logic [BASE_W-1:0] stc_base,
    input logic              ts_valid,
    input logic [BASE_W-1:0] pts,
    input logic [BASE_W-1:0] dts,
    input logic [BASE_W-1:0] reorder,
    input logic              pcr_req,
    input logic              pcr_out_valid,
    input logic              shr_stc_out_valid
);
    localparam logic [EXT_W-1:0] LAST = EXT_W'(EXT_MOD - 1);
    logic sel_tick;
    always_comb sel_tick = tick_sel ? tick_dist : tick_local;

    AST_EXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && sel_tick && !ld && cnt_ext != LAST) |=> (cnt_ext == $past(cnt_ext) + EXT_W'(1))); // R2
    AST_EXT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && sel_tick && !ld && cnt_ext == LAST) |=> (cnt_ext == '0 && cnt_base == $past(cnt_base) + BASE_W'(1))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !(is_master && sel_tick)) |=> ($stable(cnt_base) && $stable(cnt_ext))); // R3
    AST_SLAVE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> !shr_stc_out_valid); // R4
    AST_LOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_sync && !is_master) |-> $stable(stc_base)); // R6
    AST_DISC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        disc_flag |-> (cnt_base == $past(pcr_base))); // R8
    AST_PCR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pcr_out_valid |-> $past(is_encoder && pcr_req)); // R11
    AST_TS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |-> ((pts - dts) == $past(reorder))); // R12
endmodule

bind stc_unit stc_unit_chk #(.BASE_W(BASE_W), .EXT_W(EXT_W), .EXT_MOD(EXT_MOD)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .is_master        (is_master),
    .is_encoder       (is_encoder),
    .tick_sel         (tick_sel),
    .tick_local       (tick_local),
    .tick_dist        (tick_dist),
    .ld               (ld),
    .cnt_base         (cnt_base),
    .cnt_ext          (cnt_ext),
    .pcr_base         (pcr_base),
    .disc_flag        (disc_flag),
    .lost_sync        (lost_sync),
    .stc_base         (stc_base),
    .ts_valid         (ts_valid),
    .pts              (pts),
    .dts              (dts),
    .reorder          (reorder),
    .pcr_req          (pcr_req),
    .pcr_out_valid    (pcr_out_valid),
    .shr_stc_out_valid(shr_stc_out_valid)
);

// File: tb/tb_stc_unit.sv
// Self-checking bench for stc_unit: stamping table, then directed tests.
module tb_stc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        is_master = 1'b1, is_encoder = 1'b0, tick_sel = 1'b0;
    logic        tick_local = 1'b0, tick_dist = 1'b0;
    logic        pcr_valid = 1'b0;
    logic [32:0] pcr_base = '0;
    logic [8:0]  pcr_ext = '0;
    logic [32:0] disc_thresh = 33'h10;
    logic        shr_stc_in_valid = 1'b0;
    logic [32:0] shr_stc_in_base = '0;
    logic [8:0]  shr_stc_in_ext = '0;
    logic        pcr_req = 1'b0, ts_req = 1'b0;
    logic [32:0] margin = '0, reorder = '0;
    logic        shr_stc_out_valid, disc_flag, lost_sync, pcr_out_valid, ts_valid;
    logic [32:0] shr_stc_out_base, stc_base, pcr_out_base, pts, dts;
    logic [8:0]  shr_stc_out_ext, stc_ext, pcr_out_ext;

    int checks = 0;
    int errors = 0;

    localparam logic [32:0] B0 = 33'h1_FFFF_FF00;
    localparam logic [32:0] VM [4] = '{33'h10, 33'h100, 33'h200, 33'h0};
    localparam logic [32:0] VR [4] = '{33'h20, 33'h0, 33'h5, 33'h1_0000_0100};
    localparam logic [32:0] VD [4] = '{33'h1_FFFF_FF10, 33'h0, 33'h100, 33'h1_FFFF_FF00};
    localparam logic [32:0] VP [4] = '{33'h1_FFFF_FF30, 33'h0, 33'h105, 33'h1_0000_0000};

    stc_unit dut (.*);

    always #2 clk = ~clk;

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        chk("R1 stc_base", 64'(stc_base), 0);
        chk("R1 stc_ext", 64'(stc_ext), 0);
        chk("R1 out_valid", 64'(shr_stc_out_valid), 0);
        chk("R1 flags", {60'b0, disc_flag, lost_sync, pcr_out_valid, ts_valid}, 0);
        rst_n = 1'b1;

        // R7 / R9: first PCR load with a local tick in the same cycle.
        pcr_valid = 1'b1; pcr_base = B0; pcr_ext = 9'd5; tick_local = 1'b1;
        cyc();
        pcr_valid = 1'b0; tick_local = 1'b0;
        chk("R7 R9 load base", 64'(stc_base), 64'(B0));
        chk("R7 R9 load ext", 64'(stc_ext), 5);
        chk("R7 no disc", 64'(disc_flag), 0);
        chk("R4 master out", {30'b0, shr_stc_out_valid, shr_stc_out_base}, {31'b1, B0});

        // R12 / R11: timestamp table in encoder mode, count frozen.
        is_encoder = 1'b1;
        for (int i = 0; i < 4; i++) begin
            margin = VM[i]; reorder = VR[i]; ts_req = 1'b1; pcr_req = (i == 0);
            cyc();
            ts_req = 1'b0; pcr_req = 1'b0;
            chk("R12 ts_valid", 64'(ts_valid), 1);
            chk("R12 dts", 64'(dts), 64'(VD[i]));
            chk("R12 pts", 64'(pts), 64'(VP[i]));
            if (i == 0) chk("R11 pcr_out", {22'b0, pcr_out_valid, pcr_out_base, pcr_out_ext}, {22'b0, 1'b1, B0, 9'd5});
        end
        cyc();
        chk("R12 ts pulse", 64'(ts_valid), 0);
        chk("R11 pcr pulse", 64'(pcr_out_valid), 0);

        // R2: 295 ticks from ext 5 wrap the extension once.
        tick_local = 1'b1;
        repeat (295) cyc();
        tick_local = 1'b0;
        chk("R2 base step", 64'(stc_base), 64'(B0 + 33'd1));
        chk("R2 ext wrap", 64'(stc_ext), 0);

        // R3: unselected tick ignored, selected tick counted.
        tick_dist = 1'b1;
        repeat (3) cyc();
        chk("R3 unselected", 64'(stc_ext), 0);
        tick_sel = 1'b1;
        repeat (3) cyc();
        tick_dist = 1'b0;
        chk("R3 selected", 64'(stc_ext), 3);

        // R8: decoder gap 0xFE above threshold reloads near the base limit.
        is_encoder = 1'b0;
        pcr_valid = 1'b1; pcr_base = 33'h1_FFFF_FFFF; pcr_ext = 9'd299;
        cyc();
        pcr_valid = 1'b0;
        chk("R8 reload", {22'b0, disc_flag, stc_base, stc_ext}, {22'b0, 1'b1, 33'h1_FFFF_FFFF, 9'd299});
        tick_dist = 1'b1;
        cyc();
        tick_dist = 1'b0;
        chk("R2 base wrap", {22'b0, disc_flag, stc_base, stc_ext}, 0);

        // R12: ts_req ignored in decoder mode.
        ts_req = 1'b1;
        cyc();
        ts_req = 1'b0;
        chk("R12 decoder ignore", 64'(ts_valid), 0);

        // R8 / R9: in-threshold PCR with a tick: tick proceeds.
        pcr_valid = 1'b1; pcr_base = 33'h1_FFFF_FFF8; pcr_ext = 9'd7; tick_dist = 1'b1;
        cyc();
        pcr_valid = 1'b0; tick_dist = 1'b0;
        chk("R8 R9 small gap", {22'b0, disc_flag, stc_base, stc_ext}, {22'b0, 1'b0, 33'h0, 9'd1});

        pcr_valid = 1'b1; pcr_base = 33'h20; pcr_ext = 9'd0;
        cyc();
        chk("R8 large gap", {22'b0, disc_flag, stc_base, stc_ext}, {22'b0, 1'b1, 33'h20, 9'd0});
        pcr_base = 33'h30;
        cyc();
        pcr_valid = 1'b0;
        chk("R8 equal thresh", {22'b0, disc_flag, stc_base, stc_ext}, {22'b0, 1'b0, 33'h20, 9'd0});

        // R10: PCR ignored in encoder mode.
        is_encoder = 1'b1; pcr_valid = 1'b1; pcr_base = 33'h999;
        cyc();
        pcr_valid = 1'b0;
        chk("R10 encoder ignore", 64'(stc_base), 33'h20);

        // R5 / R6: slave follows shared input; PCR and ticks go nowhere.
        is_master = 1'b0; is_encoder = 1'b0;
        shr_stc_in_valid = 1'b1; shr_stc_in_base = 33'h12345; shr_stc_in_ext = 9'd77;
        pcr_valid = 1'b1; pcr_base = 33'h777; tick_dist = 1'b1;
        cyc();
        pcr_valid = 1'b0;
        chk("R5 follow", {31'b0, stc_base, stc_ext}, {31'b0, 33'h12345, 9'd77});
        chk("R4 slave out", 64'(shr_stc_out_valid), 0);
        chk("R6 in sync", 64'(lost_sync), 0);
        shr_stc_in_valid = 1'b0; shr_stc_in_base = 33'h55;
        cyc();
        chk("R6 hold", 64'(stc_base), 33'h12345);
        chk("R6 lost", 64'(lost_sync), 1);
        shr_stc_in_valid = 1'b1; shr_stc_in_ext = 9'd2;
        cyc();
        chk("R6 regain", {30'b0, lost_sync, stc_base, stc_ext}, {31'b0, 33'h55, 9'd2});

        // R11: slave encoder stamps the followed STC.
        is_encoder = 1'b1; pcr_req = 1'b1;
        cyc();
        pcr_req = 1'b0; tick_dist = 1'b0;
        chk("R11 slave stamp", {22'b0, pcr_out_valid, pcr_out_base, pcr_out_ext}, {22'b0, 1'b1, 33'h55, 9'd2});

        // R5 / R10: back to master, own count untouched during slave time.
        is_master = 1'b1;
        cyc();
        chk("R5 R10 count kept", {31'b0, stc_base, stc_ext}, {31'b0, 33'h20, 9'd0});
        chk("R6 cleared", 64'(lost_sync), 0);
        chk("R4 encoder out", 64'(shr_stc_out_valid), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule